// File: doc/BRIEF.md
# Four-Port Synchronous RAM with Byte Lanes

This block is a single storage array reached through four independent synchronous ports. Each port carries its own address, write data, two chip enables of opposite polarity, one select per byte lane, a read/write strobe and an output enable. All ports are sampled on the rising edge of one shared clock. The 18-bit word is split into a lower and an upper lane of 9 bits each. A write updates only the lanes whose selects are asserted.

A read returns the stored word one clock after its address is sampled. Each lane of the read result comes out as a value plus a drive flag. The flag is raised only when that lane was selected for the read and the port's output enable is currently asserted. The output enable acts combinationally, with no register in its path. A lane that is not driven reads as zero.

When ports collide on one address, the lower-numbered port wins a write-write conflict in each lane. A read that meets a write to the same address in the same cycle sees the old data. The ports are plain strobed memory ports with no back-pressure: every selected operation completes at the edge where it is sampled.

Top module: `quad_port_ram`

## Requirements
- R1: A port is selected only when its chip enable `ce0_n` is 0 and `ce1` is 1 at the same edge. An unselected port neither writes the array nor raises a drive flag in the next cycle.
- R2: A selected port with `rw_n` = 0 writes at the clock edge. Data bits [8:0] are stored only if `lb_n` = 0, and bits [17:9] only if `ub_n` = 0. A lane that is not selected keeps its old content.
- R3: A selected port with `rw_n` = 1 reads its address. The stored word appears on that port's `rdata` slice in the cycle after the sampling edge.
- R4: Drive flag bit 2p+0 (lower lane) or 2p+1 (upper lane) of port p is 1 only when two conditions hold: that lane's select was 0 at the read's sampling edge, and `oe_n[p]` is 0 now. `oe_n` acts combinationally, without waiting for a clock edge.
- R5: An output lane whose drive flag is 0 reads as zero on `rdata`.
- R6: When several ports write the same address in the same cycle, each lane takes the data of the lowest-numbered port writing that lane.
- R7: A read and a write to the same address in the same cycle return the data held before that write.
- R8: While `rst_n` is 0, all drive flags and all read data are 0.
- R9: A cycle with no selected read on a port clears that port's drive flags for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all ports, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| ce0_n | input | 4 | Per-port chip enable, active low |
| ce1 | input | 4 | Per-port chip enable, active high |
| rw_n | input | 4 | Per-port strobe: 0 write, 1 read |
| lb_n | input | 4 | Per-port lower-lane select, active low |
| ub_n | input | 4 | Per-port upper-lane select, active low |
| oe_n | input | 4 | Per-port output enable, active low, combinational |
| addr | input | 32 | Port p address in bits [8p+7:8p] |
| wdata | input | 72 | Port p write word in bits [18p+17:18p] |
| rdata | output | 72 | Port p read word in bits [18p+17:18p], zero where undriven |
| rdrive | output | 8 | Drive flag for port p: bit 2p lower lane, bit 2p+1 upper lane |

## Verification
The assertions check on every cycle that a raised drive flag always follows a selected read one edge earlier, that it never coexists with a deasserted output enable, that an undriven lane carries zero, and that a selected read lane raises its flag one cycle later. The contents of the array can only be shown by the bench's scenarios, which compare read-back values against a reference model. These cover lane-masked writes, write collisions resolved by port number, read-during-write ordering, chip-enable decoding, and output enable toggled between clock edges.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  // Decoded request of one port for one clock edge
  typedef struct packed {
    logic       wr;       // selected write
    logic       rd;       // selected read
    logic [1:0] lane;     // lane enables: [0] lower, [1] upper
  } port_req_t;

  localparam int LANES = 2;
endpackage

// File: rtl/qpr_port_decode.sv
module qpr_port_decode
  import qpr_pkg::*;
(
  input  logic      ce0_n_i,
  input  logic      ce1_i,
  input  logic      rw_n_i,
  input  logic      lb_n_i,
  input  logic      ub_n_i,
  output port_req_t req_o
);
  logic sel;

  // both enables must agree for the port to take part
  assign sel = ~ce0_n_i & ce1_i;

  always_comb begin
    req_o.wr   = sel & ~rw_n_i;
    req_o.rd   = sel &  rw_n_i;
    req_o.lane = {~ub_n_i, ~lb_n_i};
  end
endmodule

// File: rtl/qpr_array.sv
module qpr_array
  import qpr_pkg::*;
#(
  parameter int NP     = 4,
  parameter int AW     = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  port_req_t               req_i [NP],
  input  logic [NP*AW-1:0]        addr_i,
  input  logic [NP*LANES*LANE_W-1:0] wdata_i,
  output logic [NP*LANES*LANE_W-1:0] rdata_o,
  output logic [NP*LANES-1:0]     rlane_o
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Writes: walk ports from highest to lowest so that the lowest-numbered
  // writer is applied last and wins each lane it touches.
  always_ff @(posedge clk) begin
    for (int p = NP - 1; p >= 0; p--) begin
      if (req_i[p].wr) begin
        for (int l = 0; l < LANES; l++) begin
          if (req_i[p].lane[l])
            mem[addr_i[p*AW +: AW]][l*LANE_W +: LANE_W] <= wdata_i[p*DW + l*LANE_W +: LANE_W];
        end
      end
    end
  end

  // Reads: nonblocking capture returns the pre-write word on a same-edge hit
  for (genvar g = 0; g < NP; g++) begin : g_rd
    logic [DW-1:0]    rd_q;
    logic [LANES-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q   <= '0;
        lane_q <= '0;
      end else begin
        lane_q <= req_i[g].rd ? req_i[g].lane : '0;
        if (req_i[g].rd)
          rd_q <= mem[addr_i[g*AW +: AW]];
      end
    end

    assign rdata_o[g*DW +: DW]       = rd_q;
    assign rlane_o[g*LANES +: LANES] = lane_q;

    // R1 / R9: a held lane flag always stems from a selected read one edge back
    assert_lane_needs_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_q != '0) |-> $past(req_i[g].rd));

    // R3: a selected lower-lane read shows up as a held flag one edge later
    assert_read_latency_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[g].rd && req_i[g].lane[0]) |=> lane_q[0]);

    assert_read_latency_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[g].rd && req_i[g].lane[1]) |=> lane_q[1]);
  end
endmodule

// File: rtl/qpr_lane_gate.sv
module qpr_lane_gate
  import qpr_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] rd_i,
  input  logic [LANES-1:0]        lane_i,
  input  logic                    oe_n_i,
  output logic [LANES*LANE_W-1:0] rd_o,
  output logic [LANES-1:0]        drive_o
);
  // Output enable is deliberately unregistered
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign drive_o[l] = lane_i[l] & ~oe_n_i;
    assign rd_o[l*LANE_W +: LANE_W] = drive_o[l] ? rd_i[l*LANE_W +: LANE_W] : '0;

    // R5: an undriven lane is quiet
    assert_undriven_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_o[l] |-> (rd_o[l*LANE_W +: LANE_W] == '0));
  end
endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
  import qpr_pkg::*;
#(
  parameter int NP     = 4,
  parameter int AW     = 8,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NP-1:0]               ce0_n,
  input  logic [NP-1:0]               ce1,
  input  logic [NP-1:0]               rw_n,
  input  logic [NP-1:0]               lb_n,
  input  logic [NP-1:0]               ub_n,
  input  logic [NP-1:0]               oe_n,
  input  logic [NP*AW-1:0]            addr,
  input  logic [NP*LANES*LANE_W-1:0]  wdata,
  output logic [NP*LANES*LANE_W-1:0]  rdata,
  output logic [NP*LANES-1:0]         rdrive
);
  localparam int DW = LANES * LANE_W;

  port_req_t            req [NP];
  logic [NP*DW-1:0]     arr_rd;
  logic [NP*LANES-1:0]  arr_lane;

  for (genvar p = 0; p < NP; p++) begin : g_port
    qpr_port_decode u_dec (
      .ce0_n_i (ce0_n[p]),
      .ce1_i   (ce1[p]),
      .rw_n_i  (rw_n[p]),
      .lb_n_i  (lb_n[p]),
      .ub_n_i  (ub_n[p]),
      .req_o   (req[p])
    );

    qpr_lane_gate #(.LANE_W(LANE_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (arr_rd[p*DW +: DW]),
      .lane_i  (arr_lane[p*LANES +: LANES]),
      .oe_n_i  (oe_n[p]),
      .rd_o    (rdata[p*DW +: DW]),
      .drive_o (rdrive[p*LANES +: LANES])
    );

    // R4: no lane is driven while the port's output enable is off
    assert_drive_needs_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdrive[p*LANES +: LANES] != '0) |-> !oe_n[p]);

    // R1: a chip enable pair that does not select the port leaves it dark next cycle
    assert_unselected_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ce0_n[p] || !ce1[p]) |=> (rdrive[p*LANES +: LANES] == '0));
  end

  qpr_array #(.NP(NP), .AW(AW), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (arr_rd),
    .rlane_o (arr_lane)
  );

  // R8: reset holds the read side quiet
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R8: assert (rdrive == '0);
    end
  end
endmodule

// File: tb/tb_quad_port_ram.sv
module tb_quad_port_ram;
  localparam int CLK_P  = 10;
  localparam int NP     = 4;
  localparam int AW     = 8;
  localparam int LW     = 9;
  localparam int DW     = 2 * LW;
  localparam int DEPTH  = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic [NP-1:0] ce0_n, ce1, rw_n, lb_n, ub_n, oe_n;
  logic [NP*AW-1:0] addr;
  logic [NP*DW-1:0] wdata;
  logic [NP*DW-1:0] rdata;
  logic [NP*2-1:0]  rdrive;

  quad_port_ram #(.NP(NP), .AW(AW), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .rw_n(rw_n),
    .lb_n(lb_n), .ub_n(ub_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdrive(rdrive)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_d [NP];
  logic [1:0]    exp_l [NP];
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_port(int p, bit c0n, bit c1, bit rwn, bit lbn, bit ubn,
                          bit oen, logic [AW-1:0] a, logic [DW-1:0] d);
    ce0_n[p] = c0n; ce1[p] = c1; rw_n[p] = rwn;
    lb_n[p] = lbn; ub_n[p] = ubn; oe_n[p] = oen;
    addr[p*AW +: AW] = a; wdata[p*DW +: DW] = d;
  endtask

  task automatic idle_all();
    for (int p = 0; p < NP; p++) set_port(p, 1, 0, 1, 1, 1, 0, '0, '0);
  endtask

  // Expected drive and data for a lane from the model state and current oe_n
  function automatic logic [LW-1:0] exp_lane_data(int p, int l);
    return (exp_l[p][l] && !oe_n[p]) ? exp_d[p][l*LW +: LW] : '0;
  endfunction

  task automatic check_outputs(string tag);
    for (int p = 0; p < NP; p++) begin
      for (int l = 0; l < 2; l++) begin
        chk({tag, " drive"}, 32'(rdrive[p*2 + l]), 32'(exp_l[p][l] && !oe_n[p]));
        chk({tag, " data"}, 32'(rdata[p*DW + l*LW +: LW]), 32'(exp_lane_data(p, l)));
      end
    end
  endtask

  // Called right after a falling edge with the inputs set for the coming edge
  task automatic cycle(string tag);
    logic [DW-1:0] nd [NP];
    logic [1:0]    nl [NP];
    for (int p = 0; p < NP; p++) begin
      bit sel = !ce0_n[p] && ce1[p];
      nl[p] = 2'b00; nd[p] = exp_d[p];
      if (sel && rw_n[p]) begin
        nd[p] = model[addr[p*AW +: AW]];   // old data before this edge's writes
        nl[p] = {!ub_n[p], !lb_n[p]};
      end
    end
    for (int p = NP - 1; p >= 0; p--) begin
      if (!ce0_n[p] && ce1[p] && !rw_n[p]) begin
        if (!lb_n[p]) model[addr[p*AW +: AW]][LW-1:0]  = wdata[p*DW +: LW];
        if (!ub_n[p]) model[addr[p*AW +: AW]][DW-1:LW] = wdata[p*DW + LW +: LW];
      end
    end
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin exp_d[p] = nd[p]; exp_l[p] = nl[p]; end
    check_outputs(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_all();
    for (int p = 0; p < NP; p++) begin exp_d[p] = '0; exp_l[p] = 2'b00; end
    repeat (3) @(negedge clk);
    // R8: quiet during reset
    chk("R8 reset drive", 32'(rdrive), 32'h0);
    chk("R8 reset data", rdata[31:0], 32'h0);
    rst_n = 1;
    @(negedge clk);

    // Preload every address, four per cycle
    for (int a = 0; a < DEPTH; a += NP) begin
      for (int p = 0; p < NP; p++)
        set_port(p, 0, 1, 0, 0, 0, 0, AW'(a + p), DW'((a + p) * 1031 + 7));
      cycle("R2 preload");
    end
    idle_all();

    // R1: half-selected writes must not land
    set_port(0, 1, 1, 0, 0, 0, 0, 8'd5, 18'h3ffff); cycle("R1 ce0 high");
    set_port(0, 0, 0, 0, 0, 0, 0, 8'd5, 18'h3ffff); cycle("R1 ce1 low");
    set_port(0, 1, 1, 1, 0, 0, 0, 8'd5, '0);        cycle("R1 read unselected");
    set_port(0, 0, 1, 1, 0, 0, 0, 8'd5, '0);        cycle("R1 R3 readback");
    chk("R1 value kept", 32'(rdata[DW-1:0]), 32'(DW'(5 * 1031 + 7)));
    idle_all(); cycle("R9 idle drops flags");

    // R2: lower lane only, then upper lane only
    set_port(1, 0, 1, 0, 0, 1, 0, 8'd6, 18'h2a_b5a); cycle("R2 lower write");
    set_port(1, 0, 1, 0, 1, 0, 0, 8'd7, 18'h1c_3c3); cycle("R2 upper write");
    set_port(1, 0, 1, 1, 0, 0, 0, 8'd6, '0);         cycle("R2 read lo-written");
    set_port(1, 0, 1, 1, 0, 0, 0, 8'd7, '0);         cycle("R2 read hi-written");
    set_port(1, 0, 1, 1, 1, 0, 0, 8'd7, '0);         cycle("R4 upper-only read");
    idle_all(); cycle("R9 idle");

    // R6: all four ports write one address; port0 only upper lane
    set_port(0, 0, 1, 0, 1, 0, 0, 8'd9, 18'h00111);
    set_port(1, 0, 1, 0, 0, 0, 0, 8'd9, 18'h22222);
    set_port(2, 0, 1, 0, 0, 0, 0, 8'd9, 18'h33333);
    set_port(3, 0, 1, 0, 0, 0, 0, 8'd9, 18'h04444);
    cycle("R6 collision");
    idle_all();
    set_port(2, 0, 1, 1, 0, 0, 0, 8'd9, '0); cycle("R6 readback");
    chk("R6 winner", 32'(rdata[2*DW +: DW]), 32'({9'(18'h00111 >> 9), 9'(18'h22222)}));
    idle_all(); cycle("R9 idle");

    // R7: read during write returns old data
    set_port(0, 0, 1, 0, 0, 0, 0, 8'd10, 18'h15555);
    set_port(1, 0, 1, 1, 0, 0, 0, 8'd10, '0);
    cycle("R7 read during write");
    chk("R7 old data", 32'(rdata[DW +: DW]), 32'(DW'(10 * 1031 + 7)));
    idle_all(); cycle("R9 idle");

    // R4: oe acts without a clock edge
    set_port(3, 0, 1, 1, 0, 0, 1, 8'd11, '0); cycle("R4 oe off");
    oe_n[3] = 0; #1; check_outputs("R4 oe on between edges");
    oe_n[3] = 1; #1; check_outputs("R4 oe off between edges");
    oe_n[3] = 0;
    idle_all(); cycle("R9 idle");

    // Random mix, small address range to force collisions
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < NP; p++) begin
        int s = $urandom_range(0, 7);
        set_port(p, s == 0, s != 1, $urandom_range(0, 1), $urandom_range(0, 2) == 0,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                 AW'($urandom_range(0, 15)), DW'($urandom));
      end
      cycle("R2 R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule